// File: doc/BRIEF.md
# Trace Buffer Readout Controller

This block keeps the words captured during a debug trace run in a small ring buffer and hands them to a host through two byte-wide read registers. One register exposes the upper byte of the entry at the head of the buffer. The other exposes the lower byte. A host may peek at the upper byte first, which is optional. It then reads the lower byte, and that read moves the head on to the next stored word. Alongside the buffer the block keeps a count of the words captured in the current run. Software reads this count once the run is over to learn how many entries are valid.

The block behaves differently depending on the state of the debug unit. Captures are taken only while the unit is enabled and armed. A read is treated as a normal readout only while the unit is enabled, the arm control is low and the armed-status flag is clear. In any other state a read shows the head entry without disturbing the buffer. Two capture styles are supported. A full 16-bit word can be stored, or, in event-only mode, a single data byte. A profiling mode makes each unarmed low read store the current opcode address in the head slot, so that repeated reads sample where the program is running.

Top module: `trace_readout_ctrl`

## Requirements
- R1: After reset the word count is 0, the read data is 0x00 and both buffer pointers point at slot 0.
- R2: While enabled and armed, each `cap_valid` cycle stores `cap_word` at the write pointer and raises the word count by one. Stored entries are read back oldest first.
- R3: The word count saturates at the depth, which is 8. A capture into a full buffer overwrites the oldest entry, so after 10 captures the readout yields captures 3 to 10.
- R4: A low read (`rd_high`=0) while reads are allowed (enabled, `arm`=0, `armed_flag`=0, profiling off) returns bits 7:0 of the head entry and advances the head by one slot, wrapping modulo 8.
- R5: Readout shifts never change the word count.
- R6: A high read (`rd_high`=1) while enabled returns bits 15:8 of the head entry and never moves the head.
- R7: A low read while enabled with `arm`=1 or `armed_flag`=1 returns bits 7:0 of the head entry and does not advance the head.
- R8: In event-only mode (`event_mode`=1) a capture stores `{8'h00, cap_word[7:0]}`.
- R9: With `prof_mode`=1, a low read while reads are allowed returns bits 7:0 of the head entry, stores `pc_addr` into the head slot and does not advance the head.
- R10: A rising edge of `arm` clears the word count and both pointers. A capture in that same cycle is dropped.
- R11: While `dbg_en`=0 every read returns 0x00 and has no effect, and captures are ignored.
- R12: Read data is registered. It appears on the cycle after `rd_en` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Debug unit enable |
| arm | input | 1 | Arm control; its rising edge starts a new run |
| armed_flag | input | 1 | Armed-status flag from the trace engine |
| event_mode | input | 1 | Event-only capture: store the data byte only |
| prof_mode | input | 1 | Profiling: unarmed low reads store `pc_addr` |
| cap_valid | input | 1 | Capture strobe from the trace engine |
| cap_word | input | 16 | Word to capture |
| pc_addr | input | 16 | Current opcode address |
| rd_en | input | 1 | Host register read strobe |
| rd_high | input | 1 | 1 selects the high register, 0 the low register |
| rd_data | output | 8 | Registered read data |
| word_count | output | 4 | Valid-word count of the run |

## Verification
The readout path is exercised by reading one buffer under four different conditions: unarmed and allowed, armed by control, armed by status flag, and disabled. Only the allowed case moves the head, so the next unarmed read shows whether an earlier read shifted the buffer when it should not have. Runs of 5 captures and of 10 captures separate plain filling from saturation with overwrite. Event-only captures and profiling reads use byte values that differ from every trace word, so a missing zero-fill or a missing address store produces a distinct value.

// File: rtl/trace_ro_pkg.sv
package trace_ro_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_BLOCKED,
    RD_PEEK_HIGH,
    RD_HOLD,
    RD_PROFILE,
    RD_SHIFT
  } rd_action_e;

  // Next ring position, wrapping at depth.
  function automatic int unsigned ring_next(input int unsigned pos, input int unsigned depth);
    return (pos + 1 == depth) ? 0 : pos + 1;
  endfunction

  // Count step that stops at its limit.
  function automatic int unsigned count_step(input int unsigned cnt, input int unsigned limit);
    return (cnt >= limit) ? limit : cnt + 1;
  endfunction

endpackage

// File: rtl/trace_rd_decode.sv
module trace_rd_decode
  import trace_ro_pkg::*;
(
  input  logic       rd_en,
  input  logic       rd_high,
  input  logic       dbg_en,
  input  logic       arm,
  input  logic       armed_flag,
  input  logic       prof_mode,
  output rd_action_e action
);
  always_comb begin
    if (!rd_en)                 action = RD_NONE;
    else if (!dbg_en)           action = RD_BLOCKED;
    else if (rd_high)           action = RD_PEEK_HIGH;
    else if (arm || armed_flag) action = RD_HOLD;
    else if (prof_mode)         action = RD_PROFILE;
    else                        action = RD_SHIFT;
  end
endmodule

// File: rtl/trace_ptr_ctrl.sv
module trace_ptr_ctrl
  import trace_ro_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic          advance,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full
);
  assign full = (count == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
        count  <= CW'(count_step(int'(count), DEPTH));
        if (full) rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      end
      if (advance) begin
        rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      end
    end
  end
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] slots [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) slots[i] <= '0;
    end else if (we) begin
      slots[waddr] <= wdata;
    end
  end

  assign rword = slots[raddr];
endmodule

// File: rtl/trace_readout_ctrl.sv
module trace_readout_ctrl
  import trace_ro_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic              arm,
  input  logic              armed_flag,
  input  logic              event_mode,
  input  logic              prof_mode,
  input  logic              cap_valid,
  input  logic [WORD_W-1:0] cap_word,
  input  logic [WORD_W-1:0] pc_addr,
  input  logic              rd_en,
  input  logic              rd_high,
  output logic [HALF_W-1:0] rd_data,
  output logic [CW-1:0]     word_count
);
  // Named internal events, brought out for the checker.
  logic              arm_q;
  logic              arm_start;
  logic              cap_take;
  logic              rd_shift;
  logic              prof_store;
  logic              buf_full;
  rd_action_e        action;
  logic [AW-1:0]     wr_ptr;
  logic [AW-1:0]     rd_ptr;
  logic [WORD_W-1:0] head_word;
  logic [WORD_W-1:0] cap_entry;
  logic              st_we;
  logic [AW-1:0]     st_waddr;
  logic [WORD_W-1:0] st_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm;
  end

  assign arm_start  = arm && !arm_q;
  assign cap_take   = cap_valid && dbg_en && arm && !arm_start;
  assign cap_entry  = event_mode ? {{(WORD_W-HALF_W){1'b0}}, cap_word[HALF_W-1:0]} : cap_word;
  assign rd_shift   = (action == RD_SHIFT);
  assign prof_store = (action == RD_PROFILE);

  assign st_we    = cap_take || prof_store;
  assign st_waddr = cap_take ? wr_ptr : rd_ptr;
  assign st_wdata = cap_take ? cap_entry : pc_addr;

  trace_rd_decode u_decode (
    .rd_en      (rd_en),
    .rd_high    (rd_high),
    .dbg_en     (dbg_en),
    .arm        (arm),
    .armed_flag (armed_flag),
    .prof_mode  (prof_mode),
    .action     (action)
  );

  trace_ptr_ctrl #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (arm_start),
    .push    (cap_take),
    .advance (rd_shift),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .count   (word_count),
    .full    (buf_full)
  );

  trace_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (st_we),
    .waddr (st_waddr),
    .wdata (st_wdata),
    .raddr (rd_ptr),
    .rword (head_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      case (action)
        RD_NONE:      rd_data <= rd_data;
        RD_BLOCKED:   rd_data <= '0;
        RD_PEEK_HIGH: rd_data <= head_word[WORD_W-1:HALF_W];
        default:      rd_data <= head_word[HALF_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/trace_ro_checker.sv
module trace_ro_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned CW = 4,
  parameter int unsigned HALF_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_en,
  input logic              arm,
  input logic              armed_flag,
  input logic              rd_en,
  input logic              rd_high,
  input logic              arm_start,
  input logic              cap_take,
  input logic              rd_shift,
  input logic [AW-1:0]     rd_ptr,
  input logic [CW-1:0]     word_count,
  input logic [HALF_W-1:0] rd_data
);
  assert_count_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_count <= CW'(DEPTH));

  assert_capture_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_take && word_count < CW'(DEPTH)) |=> word_count == $past(word_count) + 1'b1);

  assert_shift_keeps_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_shift |=> $stable(word_count));

  assert_high_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_high && !cap_take && !arm_start) |=> $stable(rd_ptr));

  assert_armed_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_high && dbg_en && (arm || armed_flag) && !cap_take && !arm_start)
      |=> $stable(rd_ptr));

  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm_start |=> (word_count == '0 && rd_ptr == '0));

  assert_disabled_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !dbg_en) |=> (rd_data == '0 && $stable(rd_ptr)));
endmodule

bind trace_readout_ctrl trace_ro_checker #(
  .DEPTH(DEPTH), .AW(AW), .CW(CW), .HALF_W(HALF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dbg_en     (dbg_en),
  .arm        (arm),
  .armed_flag (armed_flag),
  .rd_en      (rd_en),
  .rd_high    (rd_high),
  .arm_start  (arm_start),
  .cap_take   (cap_take),
  .rd_shift   (rd_shift),
  .rd_ptr     (rd_ptr),
  .word_count (word_count),
  .rd_data    (rd_data)
);

// File: tb/trace_readout_ctrl_test.sv
`timescale 1ns/1ps
module trace_readout_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_en = 1'b1;
  logic        arm = 1'b0;
  logic        armed_flag = 1'b0;
  logic        event_mode = 1'b0;
  logic        prof_mode = 1'b0;
  logic        cap_valid = 1'b0;
  logic [15:0] cap_word = '0;
  logic [15:0] pc_addr = '0;
  logic        rd_en = 1'b0;
  logic        rd_high = 1'b0;
  logic [7:0]  rd_data;
  logic [3:0]  word_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  trace_readout_ctrl uut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .arm(arm), .armed_flag(armed_flag),
    .event_mode(event_mode), .prof_mode(prof_mode), .cap_valid(cap_valid),
    .cap_word(cap_word), .pc_addr(pc_addr), .rd_en(rd_en), .rd_high(rd_high),
    .rd_data(rd_data), .word_count(word_count)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Trace word number i of a run.
  function automatic logic [15:0] tw(input int i);
    return 16'hA000 + 16'(i) * 16'h0111;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input int exp);
    checks++;
    if (int'(word_count) != exp) begin
      errors++;
      $display("FAIL %s count: actual %0d expected %0d", req, word_count, exp);
    end
  endtask

  task automatic rd(input logic hi, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; rd_high = hi;
    @(negedge clk); rd_en = 1'b0; rd_high = 1'b0;
    v = rd_data;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk); cap_valid = 1'b1; cap_word = w;
    @(negedge clk); cap_valid = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk); arm = 1'b0;
    @(negedge clk); arm = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    @(negedge clk); arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_cnt("R1", 0);
    chk("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    start_run();
    for (int i = 0; i < 5; i++) push(tw(i));
    stop_run();
    chk_cnt("R2", 5);
    rd(1'b1, v); chk("R6 high peek", v, 8'hA0);
    rd(1'b1, v); chk("R6 high repeat", v, 8'hA0);
    rd(1'b0, v); chk("R4 low oldest", v, 8'h00);
    rd(1'b0, v); chk("R4 low next", v, 8'h11);
    chk_cnt("R5", 5);
    @(negedge clk); @(negedge clk);
    chk("R12 hold", rd_data, 8'h11);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    start_run();
    chk_cnt("R10 cleared", 0);
    for (int i = 0; i < 10; i++) push(tw(i));
    chk_cnt("R3 saturate", 8);
    stop_run();
    for (int i = 2; i < 10; i++) begin
      rd(1'b0, v); chk("R3 overwrite order", v, tw(i)[7:0]);
    end
    chk_cnt("R5 after full readout", 8);
  endtask

  task automatic t_armed();
    logic [7:0] v;
    start_run();
    for (int i = 0; i < 3; i++) push(tw(i));
    rd(1'b0, v); chk("R7 armed read", v, 8'h00);
    rd(1'b0, v); chk("R7 armed no shift", v, 8'h00);
    @(negedge clk); arm = 1'b0; armed_flag = 1'b1;
    rd(1'b0, v); chk("R7 flag read", v, 8'h00);
    @(negedge clk); armed_flag = 1'b0;
    rd(1'b0, v); chk("R7 head kept", v, 8'h00);
    rd(1'b0, v); chk("R4 shift resumes", v, 8'h11);
    chk_cnt("R7", 3);
  endtask

  task automatic t_event();
    logic [7:0] v;
    event_mode = 1'b1;
    start_run();
    push(16'hBEEF);
    stop_run();
    event_mode = 1'b0;
    rd(1'b1, v); chk("R8 upper zero", v, 8'h00);
    rd(1'b0, v); chk("R8 data byte", v, 8'hEF);
    chk_cnt("R8", 1);
  endtask

  task automatic t_profile();
    logic [7:0] v;
    start_run();
    push(tw(0)); push(tw(1));
    stop_run();
    prof_mode = 1'b1; pc_addr = 16'h4321;
    rd(1'b0, v); chk("R9 first read", v, 8'h00);
    rd(1'b1, v); chk("R9 stored high", v, 8'h43);
    rd(1'b0, v); chk("R9 stored low", v, 8'h21);
    pc_addr = 16'h5678;
    rd(1'b0, v); chk("R9 previous sample", v, 8'h21);
    rd(1'b1, v); chk("R9 new sample", v, 8'h56);
    chk_cnt("R9", 2);
    prof_mode = 1'b0;
    rd(1'b0, v); chk("R9 shift after profile", v, 8'h78);
    rd(1'b0, v); chk("R9 next entry", v, 8'h11);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    start_run();
    push(tw(5));
    stop_run();
    @(negedge clk); dbg_en = 1'b0;
    rd(1'b0, v); chk("R11 low blocked", v, 8'h00);
    rd(1'b1, v); chk("R11 high blocked", v, 8'h00);
    @(negedge clk); dbg_en = 1'b1;
    rd(1'b0, v); chk("R11 head untouched", v, 8'h55);
    @(negedge clk); dbg_en = 1'b0;
    start_run();
    push(tw(6)); push(tw(7));
    chk_cnt("R11 capture ignored", 0);
    stop_run();
    dbg_en = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_overflow();
    t_armed();
    t_event();
    t_profile();
    t_disabled();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule